// File: doc/BRIEF.md
# Program Exception State Capture

This block holds the machine-state word of a 32-bit core and updates the interrupt save state when a program-class exception is taken. An exception strobe arrives with a type code and the faulting instruction's attributes. On the same clock edge the block saves the faulting address and the current machine-state word, strips the machine-state word down to its three protected enables, and writes a syndrome word that tells the handler why it was entered.

The block also detects a delayed floating-point enabled exception. A machine-state write can switch the floating-point exception-mode field from all-zero to non-zero while the floating-point exception summary input is already high. That write then raises an imprecise exception. The saved address points past the write: to the next sequential instruction, or to the return target when the write came from a return-from-interrupt.

Top module: `prog_exc_capture`

## Requirements
- R1: On entry `srr1_o` receives the machine-state word in force at the interrupt. For an explicit exception that is `msr_o` before the edge. For a delayed entry it is `msr_wdata`, the value just written.
- R2: On entry the new `msr_o` keeps only the critical-enable (bit 17), machine-check-enable (bit 12) and debug-enable (bit 9) bits of the saved word. All other bits become 0.
- R3: The syndrome type bits `esr_o[3:0]` are one-hot by `exc_type`: 0 illegal sets bit 0, 1 privileged sets bit 1, 2 trap sets bit 2, 3 unimplemented sets bit 3. Codes 4 to 7 set none of them.
- R4: For an explicit exception, `esr_o[4]` copies `ins_fp` and `esr_o[5]` copies `ins_ap`.
- R5: A delayed entry is raised when all of these hold: `msr_wr` is high, `exc_valid` is low, `fp_summary` is high, the exception-mode bits (11 and 8) of `msr_o` are both 0, and at least one of them is 1 in `msr_wdata`. In that case `esr_o` is exactly bit 6 (imprecise). Bit 6 is 0 on every explicit entry.
- R6: On a delayed entry `srr0_o` is `rfi_target` when `msr_wr_is_rfi` is high, and `next_addr` otherwise.
- R7: With `exc_type` 4 (precise floating-point enabled), `esr_o[7]` copies `ins_cr_upd`, `esr_o[8]` copies `ins_cmp`, and `esr_o[11:9]` copies `ins_crf`. For any other type these bits are 0.
- R8: On an explicit exception `srr0_o` receives `ins_addr`.
- R9: When `exc_valid` and a delayed-triggering write occur in the same cycle, the explicit exception is taken. The write is discarded.
- R10: A synchronous active-high `rst` clears every output to 0.
- R11: A machine-state write that does not meet R5 loads `msr_wdata` into `msr_o`. It leaves `srr0_o`, `srr1_o` and `esr_o` unchanged and raises no `entry_o`.
- R12: `entry_o` is high for exactly the one cycle after an accepted entry edge, and all results of that entry appear together at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Explicit program exception strobe |
| exc_type | input | 3 | Exception type code |
| ins_fp | input | 1 | Faulting instruction is floating-point |
| ins_ap | input | 1 | Faulting instruction is auxiliary-processor |
| ins_cr_upd | input | 1 | Faulting FP instruction updates a CR field |
| ins_cmp | input | 1 | Faulting FP instruction is a compare |
| ins_crf | input | 3 | Target CR field number |
| ins_addr | input | AW | Address of faulting instruction |
| next_addr | input | AW | Address after the machine-state writing instruction |
| msr_wr | input | 1 | Machine-state write event |
| msr_wdata | input | MW | Value being written |
| msr_wr_is_rfi | input | 1 | Write comes from a return-from-interrupt |
| rfi_target | input | AW | Return target of that instruction |
| fp_summary | input | 1 | Floating-point exception summary pending |
| entry_o | output | 1 | Exception entry pulse |
| srr0_o | output | AW | Saved address |
| srr1_o | output | MW | Saved machine-state word |
| msr_o | output | MW | Current machine-state word |
| esr_o | output | 12 | Syndrome word |

## Verification
Every result of an entry or a plain write is registered once, so it is due at the first rising edge after the stimulus cycle. The bench drives on a falling edge and checks at the next falling edge, one edge later. At that point `entry_o`, both save registers, the machine-state word and the syndrome must all agree together. Checks that some stimulus has no effect are sampled at the same point, and again after a following idle cycle.

// File: rtl/prog_exc_capture.sv
module prog_exc_capture #(
  parameter int AW      = 32,
  parameter int MW      = 32,
  parameter int CE_BIT  = 17,
  parameter int ME_BIT  = 12,
  parameter int DE_BIT  = 9,
  parameter int FE0_BIT = 11,
  parameter int FE1_BIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exc_valid,
  input  logic [2:0]    exc_type,
  input  logic          ins_fp,
  input  logic          ins_ap,
  input  logic          ins_cr_upd,
  input  logic          ins_cmp,
  input  logic [2:0]    ins_crf,
  input  logic [AW-1:0] ins_addr,
  input  logic [AW-1:0] next_addr,
  input  logic          msr_wr,
  input  logic [MW-1:0] msr_wdata,
  input  logic          msr_wr_is_rfi,
  input  logic [AW-1:0] rfi_target,
  input  logic          fp_summary,
  output logic          entry_o,
  output logic [AW-1:0] srr0_o,
  output logic [MW-1:0] srr1_o,
  output logic [MW-1:0] msr_o,
  output logic [11:0]   esr_o
);
  localparam logic [MW-1:0] KEEP_MASK =
    (MW'(1) << CE_BIT) | (MW'(1) << ME_BIT) | (MW'(1) << DE_BIT);
  localparam logic [MW-1:0] FE_MASK = (MW'(1) << FE0_BIT) | (MW'(1) << FE1_BIT);
  localparam int IMP_BIT = 6;

  logic        fe_now, fe_next, delayed, fp_enabled;
  logic [11:0] esr_precise;

  assign fe_now     = |(msr_o & FE_MASK);
  assign fe_next    = |(msr_wdata & FE_MASK);
  assign delayed    = msr_wr & ~exc_valid & fp_summary & ~fe_now & fe_next;
  assign fp_enabled = (exc_type == 3'd4);

  always_comb begin
    esr_precise = '0;
    if (exc_type < 3'd4) esr_precise[exc_type[1:0]] = 1'b1;
    esr_precise[4] = ins_fp;
    esr_precise[5] = ins_ap;
    if (fp_enabled) begin
      esr_precise[7]    = ins_cr_upd;
      esr_precise[8]    = ins_cmp;
      esr_precise[11:9] = ins_crf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_o <= 1'b0;
      srr0_o  <= '0;
      srr1_o  <= '0;
      msr_o   <= '0;
      esr_o   <= '0;
    end else begin
      entry_o <= exc_valid | delayed;
      if (exc_valid) begin
        srr0_o <= ins_addr;
        srr1_o <= msr_o;
        msr_o  <= msr_o & KEEP_MASK;
        esr_o  <= esr_precise;
      end else if (delayed) begin
        srr0_o <= msr_wr_is_rfi ? rfi_target : next_addr;
        srr1_o <= msr_wdata;
        msr_o  <= msr_wdata & KEEP_MASK;
        esr_o  <= 12'(1) << IMP_BIT;
      end else if (msr_wr) begin
        msr_o <= msr_wdata;
      end
    end
  end
endmodule

module prog_exc_capture_chk #(
  parameter int AW = 32,
  parameter int MW = 32,
  parameter logic [MW-1:0] KEEP_MASK = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          exc_valid,
  input logic          msr_wr,
  input logic [MW-1:0] msr_wdata,
  input logic          entry_o,
  input logic [AW-1:0] srr0_o,
  input logic [MW-1:0] srr1_o,
  input logic [MW-1:0] msr_o,
  input logic [11:0]   esr_o
);
  p_srr1_exc_r1: assert property (@(posedge clk) disable iff (rst)
    $past(exc_valid) && !$past(rst) |-> srr1_o == $past(msr_o));
  p_msr_clear_r2: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> (msr_o & ~KEEP_MASK) == '0);
  p_msr_keep_r2: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> msr_o == (srr1_o & KEEP_MASK));
  p_type_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(esr_o[3:0]));
  p_no_imp_exc_r5: assert property (@(posedge clk) disable iff (rst)
    $past(exc_valid) && !$past(rst) |-> !esr_o[6]);
  p_imp_alone_r5: assert property (@(posedge clk) disable iff (rst)
    esr_o[6] |-> esr_o == 12'h040);
  p_save_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !entry_o |-> $stable(srr0_o) && $stable(srr1_o) && $stable(esr_o));
  p_entry_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    entry_o && !$past(rst) |-> $past(exc_valid) || $past(msr_wr));
endmodule

bind prog_exc_capture prog_exc_capture_chk #(.AW(AW), .MW(MW), .KEEP_MASK(KEEP_MASK)) chk_i (
  .clk(clk), .rst(rst), .exc_valid(exc_valid), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
  .entry_o(entry_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o), .esr_o(esr_o));

// File: tb/prog_exc_capture_tb_top.sv
module prog_exc_capture_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic        exc_valid = 0, ins_fp = 0, ins_ap = 0, ins_cr_upd = 0, ins_cmp = 0;
  logic [2:0]  exc_type = 0, ins_crf = 0;
  logic [31:0] ins_addr = 0, next_addr = 0, msr_wdata = 0, rfi_target = 0;
  logic        msr_wr = 0, msr_wr_is_rfi = 0, fp_summary = 0;
  logic        entry_o;
  logic [31:0] srr0_o, srr1_o, msr_o;
  logic [11:0] esr_o;
  int total = 0, failed = 0;

  prog_exc_capture dut_i (.*);

  always #2 clk = ~clk;

  // {type[21:19], fp, ap, cr_upd, cmp, crf[14:12], expected esr[11:0]}
  localparam logic [21:0] VEC [8] = '{
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 12'h001},
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 12'h012},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 12'h024},
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 12'h038},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 12'h690},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 3'd7, 12'hF90},
    {3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 12'h010},
    {3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 12'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_msr(input logic [31:0] v);
    @(negedge clk);
    msr_wr = 1; msr_wdata = v;
    @(negedge clk);
    msr_wr = 0; msr_wr_is_rfi = 0;
  endtask

  initial begin
    #800000;
    total++; failed++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 entry", {31'd0, entry_o}, 0);
    chk("R10 srr0", srr0_o, 0);
    chk("R10 msr", msr_o, 0);
    chk("R10 esr", {20'd0, esr_o}, 0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] pat;
      pat = 32'hF6FF_F6FF ^ (32'h0001_1011 * i);
      pat = pat & ~32'h0000_0900;
      write_msr(pat);
      chk("R11 msr write", msr_o, pat);
      chk("R11 no entry", {31'd0, entry_o}, 0);
      exc_valid = 1;
      {exc_type, ins_fp, ins_ap, ins_cr_upd, ins_cmp, ins_crf} = VEC[i][21:12];
      ins_addr = 32'h0000_4000 + 32'(i * 4);
      @(negedge clk);
      exc_valid = 0;
      chk("R12 entry", {31'd0, entry_o}, 1);
      chk("R8 srr0", srr0_o, 32'h0000_4000 + 32'(i * 4));
      chk("R1 srr1", srr1_o, pat);
      chk("R2 msr", msr_o, pat & 32'h0002_1200);
      chk("R3 R4 R7 esr", {20'd0, esr_o}, {20'd0, VEC[i][11:0]});
      @(negedge clk);
      chk("R12 pulse", {31'd0, entry_o}, 0);
    end

    fp_summary = 1;
    write_msr(32'h0002_0000);
    chk("R11 fe off", msr_o, 32'h0002_0000);
    @(negedge clk);
    msr_wr = 1; msr_wdata = 32'h0002_0800; next_addr = 32'h0000_1004;
    rfi_target = 32'h0000_7000; msr_wr_is_rfi = 0;
    @(negedge clk);
    msr_wr = 0;
    chk("R5 entry", {31'd0, entry_o}, 1);
    chk("R6 seq srr0", srr0_o, 32'h0000_1004);
    chk("R1 delayed srr1", srr1_o, 32'h0002_0800);
    chk("R2 delayed msr", msr_o, 32'h0002_0000);
    chk("R5 esr", {20'd0, esr_o}, 32'h040);

    @(negedge clk);
    msr_wr = 1; msr_wdata = 32'h0000_1100; msr_wr_is_rfi = 1; rfi_target = 32'h0000_2000;
    @(negedge clk);
    msr_wr = 0; msr_wr_is_rfi = 0;
    chk("R6 rfi srr0", srr0_o, 32'h0000_2000);
    chk("R2 rfi msr", msr_o, 32'h0000_1000);
    chk("R5 rfi esr", {20'd0, esr_o}, 32'h040);

    fp_summary = 0;
    write_msr(32'h0000_0900);
    chk("R11 no summary msr", msr_o, 32'h0000_0900);
    chk("R11 no summary srr0", srr0_o, 32'h0000_2000);
    chk("R11 no summary entry", {31'd0, entry_o}, 0);
    fp_summary = 1;
    write_msr(32'h0000_0100);
    chk("R11 fe already on", msr_o, 32'h0000_0100);
    chk("R11 fe already on esr", {20'd0, esr_o}, 32'h040);
    chk("R11 fe already on entry", {31'd0, entry_o}, 0);

    write_msr(32'h0000_0200);
    @(negedge clk);
    exc_valid = 1; exc_type = 3'd2; ins_fp = 0; ins_ap = 0; ins_addr = 32'h0000_9000;
    msr_wr = 1; msr_wdata = 32'h0000_0800; next_addr = 32'h0000_1234;
    @(negedge clk);
    exc_valid = 0; msr_wr = 0;
    chk("R9 srr0", srr0_o, 32'h0000_9000);
    chk("R9 srr1", srr1_o, 32'h0000_0200);
    chk("R9 msr", msr_o, 32'h0000_0200);
    chk("R9 esr", {20'd0, esr_o}, 32'h004);
    @(negedge clk);
    chk("R9 write dropped", msr_o, 32'h0000_0200);

    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10 srr1", srr1_o, 0);
    chk("R10 msr again", msr_o, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule